// File: doc/BRIEF.md
# Growing-Bar Sign Lamp Sequencer

This block steps a roadside sign through a four-phase lighting pattern that grows from dark to fully lit and then starts over. Five lamps are driven through three grouped controls: one for the first pair, one for the second pair, and one for the single arrow-tip lamp. The controls are cumulative, so once a group is lit, every group before it is also lit.

The sequence runs only while the enable switch is on. Turning the switch off does not freeze the pattern. On the next clock edge the machine goes back to the dark phase, and it stays there until the switch is turned on again.

A step divider sets the stepping rate. With a terminal count of N, the pattern advances once every N clock cycles while enabled. N = 1 steps on every edge. The lamp controls are decoded from the state register alone, with no combinational path from the switch.

States, in 2-bit encoding order:
- `ST_DARK` (00): all off.
- `ST_PAIR` (01): first pair lit.
- `ST_QUAD` (10): both pairs lit.
- `ST_FULL` (11): all five lit.

Transitions:
- DARK→PAIR, PAIR→QUAD, QUAD→FULL and FULL→DARK occur on a divider step while the switch is on.
- Any state goes to DARK when the switch is off.
- A state holds when the switch is on but no step is due.

Top module: `lamp_ramp_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes DARK, and all three lamp outputs read 0 after that edge.
- R2: With the switch on and STEP_DIV = 1, each clock edge advances DARK→PAIR→QUAD→FULL→DARK, repeating without end.
- R3: `lamp_pair` is 1 in PAIR, QUAD and FULL, and 0 in DARK. The output triple (pair, mid, tip) reads 000, 100, 110, 111 for states 00, 01, 10, 11.
- R4: `lamp_mid` is 1 only in QUAD and FULL.
- R5: `lamp_tip` is 1 only in FULL.
- R6: If the switch is 0 at a clock edge, the state after that edge is DARK, whichever state it was in.
- R7: While the switch stays 0, the outputs stay at 000 on every edge.
- R8: With STEP_DIV = N, the state advances exactly once per N edges while the switch is on. The state holds on the other edges. The divider count restarts while the switch is off, so the first advance comes on the N-th edge after the switch turns on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sw_on | input | 1 | Enable switch; 0 returns the sign to dark |
| lamp_pair | output | 1 | Control for lamps 1 and 2 |
| lamp_mid | output | 1 | Control for lamps 3 and 4 |
| lamp_tip | output | 1 | Control for lamp 5 |

## Verification
The bench builds two copies of the block side by side with a shared switch and reset. One uses STEP_DIV = 1, which makes every edge a step, so several full laps and a switch-off from each of the four states are reached within a few dozen cycles. The other uses STEP_DIV = 3, which exposes the hold edges between steps and the restart of the divider count after the switch has been off. An arithmetic model of phase and divider count in the bench predicts all six outputs on every edge.

// File: rtl/lamp_ramp_pkg.sv
package lamp_ramp_pkg;
    typedef enum logic [1:0] {
        ST_DARK = 2'b00,
        ST_PAIR = 2'b01,
        ST_QUAD = 2'b10,
        ST_FULL = 2'b11
    } lamp_state_e;

    typedef struct packed {
        logic pair;
        logic mid;
        logic tip;
    } lamp_out_t;
endpackage

// File: rtl/lamp_step_div.sv
module lamp_step_div #(
    parameter int STEP_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic step
);
    localparam int CW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
    localparam logic [CW-1:0] TC = CW'(STEP_DIV - 1);

    logic [CW-1:0] cnt_q;

    generate
        if (STEP_DIV <= 1) begin : g_bypass
            assign step = run;
            always_ff @(posedge clk) begin
                cnt_q <= '0;
            end
        end else begin : g_count
            assign step = run && (cnt_q == TC);
            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt_q <= '0;
                end else if (cnt_q == TC) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            // R8: steps are never back to back when dividing
            p_step_gap_r8: assert property (@(posedge clk) disable iff (rst)
                step |=> !step);
            // R8: switch off clears the count so no step follows at once
            p_restart_r8: assert property (@(posedge clk) disable iff (rst)
                !run |=> !step);
        end
    endgenerate
endmodule

// File: rtl/lamp_ramp_fsm.sv
module lamp_ramp_fsm
    import lamp_ramp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sw_on,
    input  logic        step,
    output lamp_state_e state
);
    lamp_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!sw_on) begin
            state_d = ST_DARK;
        end else if (step) begin
            unique case (state_q)
                ST_DARK: state_d = ST_PAIR;
                ST_PAIR: state_d = ST_QUAD;
                ST_QUAD: state_d = ST_FULL;
                ST_FULL: state_d = ST_DARK;
                default: state_d = ST_DARK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_DARK;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

    // R6: switch off returns to dark on the next edge
    p_off_dark_r6: assert property (@(posedge clk) disable iff (rst)
        !sw_on |=> (state_q == ST_DARK));
    // R2: full wraps to dark on a step
    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (sw_on && step && state_q == ST_FULL) |=> (state_q == ST_DARK));
    // R2: other states move up by one on a step
    p_advance_r2: assert property (@(posedge clk) disable iff (rst)
        (sw_on && step && state_q != ST_FULL)
            |=> (2'(state_q) == 2'($past(state_q) + 2'd1)));
    // R8: no step means the state holds
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (sw_on && !step) |=> $stable(state_q));
endmodule

// File: rtl/lamp_out_dec.sv
module lamp_out_dec
    import lamp_ramp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  lamp_state_e state,
    output lamp_out_t   lamps
);
    always_comb begin
        lamps = '0;
        unique case (state)
            ST_DARK: lamps = '{pair: 1'b0, mid: 1'b0, tip: 1'b0};
            ST_PAIR: lamps = '{pair: 1'b1, mid: 1'b0, tip: 1'b0};
            ST_QUAD: lamps = '{pair: 1'b1, mid: 1'b1, tip: 1'b0};
            ST_FULL: lamps = '{pair: 1'b1, mid: 1'b1, tip: 1'b1};
            default: lamps = '0;
        endcase
    end

    // R4: second pair never lit without the first
    p_mid_nest_r4: assert property (@(posedge clk) disable iff (rst)
        lamps.mid |-> lamps.pair);
    // R5: tip never lit without both pairs
    p_tip_nest_r5: assert property (@(posedge clk) disable iff (rst)
        lamps.tip |-> (lamps.mid && lamps.pair));
    // R3: dark state shows nothing
    p_dark_blank_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DARK) |-> ($countones({lamps.pair, lamps.mid, lamps.tip}) == 0));
endmodule

// File: rtl/lamp_ramp_seq.sv
module lamp_ramp_seq
    import lamp_ramp_pkg::*;
#(
    parameter int STEP_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_on,
    output logic lamp_pair,
    output logic lamp_mid,
    output logic lamp_tip
);
    logic        step;
    lamp_state_e state;
    lamp_out_t   lamps;

    lamp_step_div #(.STEP_DIV(STEP_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (sw_on),
        .step (step)
    );

    lamp_ramp_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .sw_on (sw_on),
        .step  (step),
        .state (state)
    );

    lamp_out_dec u_dec (
        .clk   (clk),
        .rst   (rst),
        .state (state),
        .lamps (lamps)
    );

    assign lamp_pair = lamps.pair;
    assign lamp_mid  = lamps.mid;
    assign lamp_tip  = lamps.tip;

    // R1: reset leaves the sign dark
    p_reset_dark_r1: assert property (@(posedge clk)
        rst |=> (!lamp_pair && !lamp_mid && !lamp_tip));
endmodule

// File: tb/tb_lamp_ramp_seq.sv
module tb_lamp_ramp_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sw  = 1'b0;
    logic a_pair, a_mid, a_tip;
    logic b_pair, b_mid, b_tip;

    int checks = 0;
    int errors = 0;
    int ph_a = 0;
    int ph_b = 0;
    int cnt_b = 0;

    always #10 clk = ~clk;

    lamp_ramp_seq #(.STEP_DIV(1)) dut (
        .clk(clk), .rst(rst), .sw_on(sw),
        .lamp_pair(a_pair), .lamp_mid(a_mid), .lamp_tip(a_tip)
    );

    lamp_ramp_seq #(.STEP_DIV(3)) dut_div (
        .clk(clk), .rst(rst), .sw_on(sw),
        .lamp_pair(b_pair), .lamp_mid(b_mid), .lamp_tip(b_tip)
    );

    function automatic logic [2:0] pattern(input int ph);
        return {ph >= 1, ph >= 2, ph == 3};
    endfunction

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        if (rst || !sw) begin
            ph_a = 0; ph_b = 0; cnt_b = 0;
        end else begin
            ph_a = (ph_a + 1) % 4;
            if (cnt_b == 2) begin
                cnt_b = 0;
                ph_b = (ph_b + 1) % 4;
            end else begin
                cnt_b++;
            end
        end
        #1;
        check(tag, {a_pair, a_mid, a_tip}, pattern(ph_a));
        check({tag, " R8"}, {b_pair, b_mid, b_tip}, pattern(ph_b));
    endtask

    initial begin
        #(20 * 5000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) tick("R1");
        rst = 1'b0;
        tick("R7");
        sw = 1'b1;
        // several full laps: R2 ordering, R3/R4/R5 decode
        for (int i = 0; i < 16; i++) tick("R2 R3 R4 R5");
        // switch off from each state on the fast copy
        for (int s = 0; s < 4; s++) begin
            sw = 1'b1;
            while (ph_a != s) tick("R2");
            sw = 1'b0;
            tick("R6");
            for (int k = 0; k < 2; k++) tick("R7");
        end
        // divided copy: switch off from each of its states
        for (int s = 0; s < 4; s++) begin
            sw = 1'b1;
            while (ph_b != s) tick("R8");
            tick("R8");
            sw = 1'b0;
            tick("R6");
        end
        // reset in mid-sequence
        sw = 1'b1;
        for (int i = 0; i < 7; i++) tick("R2");
        rst = 1'b1;
        tick("R1");
        rst = 1'b0;
        for (int i = 0; i < 9; i++) tick("R8");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule